// File: doc/BRIEF.md
# Narrow Data Bus Beat Sequencer

This block carries processor data transactions over a 64-bit data bus that runs in its 32-bit mode. Only the upper half of the bus, byte lanes 0 to 3, carries data, and each of those lanes has its own parity bit. The lower half and its parity bits are driven low on every cycle.

A request is classed as one of three kinds: a single access of one to four bytes, an aligned double-word floating-point access, or a cache line transfer. The class sets the length of the tenure (1, 2 or 8 beats) and the burst and size codes that are held on the bus for that tenure. The block then steps through 32-bit beats. It moves on by one beat for each transfer-acknowledge strobe. On writes it drives each beat's word with odd parity. On reads it captures each beat into a line-wide result and checks the parity.

Arbitration and retry are handled outside the block. A request that is accepted starts its tenure on the next clock edge and occupies the bus until its last beat is acknowledged.

Top module: `narrow_bus_seq`

## Requirements
- R1: After reset `busy`, `done`, `rd_perr` and `bus_burst` are 0, `bus_size` is 3'b000, and every bus data and parity output is 0. Outside a tenure the burst flag, the size code, `bus_dh_out` and `bus_dp_out` stay 0.
- R2: `bus_dl_out` and `bus_dp_out[7:4]` (lanes 4 to 7) are 0 at all times, including during write beats.
- R3: Kind 2'b00 with `req_bytes` from 1 to 4 gives a one-beat tenure. The burst flag is 0 and the size code equals the byte count (3'b001 to 3'b100). The beat carries `req_wdata[31:0]`, and a read lands in `rd_data[31:0]`.
- R4: Kind 2'b01 with `req_dw_off` equal to 0 gives a two-beat tenure. The burst flag is 0 and the size code is 3'b000. Beat 0 carries the high word `[63:32]` and beat 1 the low word `[31:0]`, for both writes and reads.
- R5: Kind 2'b10 gives an eight-beat tenure. The burst flag is 1 and the size code is 3'b010. Beat k carries word `[32k+31:32k]`, in ascending order starting at word 0.
- R6: The block ignores a request and does not raise `busy` in any of these cases: kind 2'b11; a single access with a byte count of 0 or more than 4; a double-word access with a nonzero offset; a line request with `req_ci` set; a line write with `req_wt` set. A line read with `req_wt` set is accepted.
- R7: On write beats, `bus_dp_out[i]` is the odd parity of lane i, where lane i is `bus_dh_out[31-8i:24-8i]`. On reads, a beat whose `bus_dp_in[i]` does not give odd parity with its lane sets `rd_perr` together with `done`. A clean tenure leaves `rd_perr` at 0.
- R8: `busy` rises on the edge after an accepted request. The beat advances only on an edge where `bus_ta` is high, and the data stays put while `bus_ta` is low. `done` pulses for one cycle after the edge that carries the last acknowledge, and `busy` is low in that cycle. Requests are ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | 00 single, 01 FP double word, 10 cache line |
| req_write | input | 1 | 1 for store or castback |
| req_bytes | input | 3 | Byte count of a single access |
| req_dw_off | input | 3 | Byte offset within the double word |
| req_ci | input | 1 | Caching-inhibited attribute |
| req_wt | input | 1 | Write-through attribute |
| req_wdata | input | 32*LINE_WORDS | Write data, word k at bits 32k+ |
| bus_ta | input | 1 | Transfer-acknowledge beat strobe |
| bus_dh_in | input | 32 | Read data, lanes 0 to 3 |
| bus_dp_in | input | 4 | Read parity, bit i for lane i |
| busy | output | 1 | Tenure in progress |
| bus_burst | output | 1 | Burst indication |
| bus_size | output | 3 | Transfer size code |
| bus_dh_out | output | 32 | Write data, lanes 0 to 3 |
| bus_dl_out | output | 32 | Lanes 4 to 7, always low |
| bus_dp_out | output | 8 | Write parity, bit i for lane i |
| rd_data | output | 32*LINE_WORDS | Captured read data |
| done | output | 1 | One-cycle end-of-tenure pulse |
| rd_perr | output | 1 | Read parity error, valid with done |

## Verification
The bench drives single, double-word and line requests, both reads and writes, with different byte counts and attribute settings. These patterns separate the three tenure lengths and their burst and size codes from each other. Reversed word order in the two-beat case and descending order in the line case give different words on the bus from the very first beat, so either fault is caught. The rejected patterns (bad byte counts, a misaligned double word, caching-inhibited and write-through lines, the reserved kind) sit next to accepted ones that differ in one field only, so an over-strict decode and an over-lenient one are both caught. A stalled beat, a request made during a tenure and a single corrupted parity lane separate proper acknowledge pacing from free-running beats and show that error reporting is tied to one tenure.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

  localparam int WORD_W = 32;
  localparam int LANES  = 4;

  typedef enum logic [1:0] {
    KIND_SINGLE = 2'b00,
    KIND_FPDW   = 2'b01,
    KIND_LINE   = 2'b10,
    KIND_RSVD   = 2'b11
  } req_kind_e;

  // odd parity bit for one byte lane
  function automatic logic odd_par(input logic [7:0] b);
    return ~^b;
  endfunction

  // per-lane parity of a word; lane i is the i-th byte from the top
  function automatic logic [LANES-1:0] lane_par(input logic [WORD_W-1:0] w);
    logic [LANES-1:0] p;
    for (int i = 0; i < LANES; i++) p[i] = odd_par(w[WORD_W-1-8*i -: 8]);
    return p;
  endfunction

  // word slot a beat maps to: double words go high word first
  function automatic int unsigned beat_slot(input logic fpdw, input int unsigned beat);
    if (fpdw) return (beat == 0) ? 1 : 0;
    return beat;
  endfunction

endpackage

// File: rtl/nbs_classify.sv
module nbs_classify
  import nbs_pkg::*;
#(
  parameter int LINE_WORDS = 8,
  localparam int BEAT_W = $clog2(LINE_WORDS)
) (
  input  logic [1:0]        kind,
  input  logic              write,
  input  logic [2:0]        nbytes,
  input  logic [2:0]        dw_off,
  input  logic              ci,
  input  logic              wt,
  output logic              ok,
  output logic [BEAT_W-1:0] last_idx,
  output logic              burst,
  output logic [2:0]        size_code
);

  always_comb begin
    ok        = 1'b0;
    last_idx  = '0;
    burst     = 1'b0;
    size_code = 3'b000;
    case (req_kind_e'(kind))
      KIND_SINGLE: begin
        ok        = (nbytes != 3'd0) && (nbytes <= 3'd4);
        size_code = nbytes;
      end
      KIND_FPDW: begin
        ok       = (dw_off == 3'd0);
        last_idx = BEAT_W'(1);
      end
      KIND_LINE: begin
        ok        = !ci && !(wt && write);
        last_idx  = BEAT_W'(LINE_WORDS - 1);
        burst     = 1'b1;
        size_code = 3'b010;
      end
      default: ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/nbs_beat_ctr.sv
module nbs_beat_ctr #(
  parameter int BEAT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BEAT_W-1:0] last_in,
  input  logic              ta,
  output logic              busy,
  output logic [BEAT_W-1:0] beat,
  output logic [BEAT_W-1:0] last_idx,
  output logic              final_ta,
  output logic              done
);

  assign final_ta = busy && ta && (beat == last_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      beat     <= '0;
      last_idx <= '0;
      done     <= 1'b0;
    end else begin
      done <= final_ta;
      if (start) begin
        busy     <= 1'b1;
        beat     <= '0;
        last_idx <= last_in;
      end else if (final_ta) begin
        busy <= 1'b0;
        beat <= '0;
      end else if (busy && ta) begin
        beat <= beat + BEAT_W'(1);
      end
    end
  end

endmodule

// File: rtl/nbs_lane_io.sv
module nbs_lane_io
  import nbs_pkg::*;
#(
  parameter int LINE_WORDS = 8,
  localparam int BEAT_W = $clog2(LINE_WORDS),
  localparam int LINE_W = WORD_W * LINE_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              busy,
  input  logic              wr,
  input  logic              fpdw,
  input  logic [BEAT_W-1:0] beat,
  input  logic              ta,
  input  logic              final_ta,
  input  logic [LINE_W-1:0] wdata,
  input  logic [WORD_W-1:0] dh_in,
  input  logic [LANES-1:0]  dp_in,
  output logic [WORD_W-1:0] dh_out,
  output logic [WORD_W-1:0] dl_out,
  output logic [7:0]        dp_out,
  output logic [LINE_W-1:0] rdata,
  output logic              perr
);

  logic [BEAT_W-1:0] slot;
  logic [WORD_W-1:0] cur_word;
  logic              drive;
  logic              capture;
  logic              beat_err;
  logic              err_acc;

  assign slot     = BEAT_W'(beat_slot(fpdw, int'(beat)));
  assign cur_word = wdata[slot*WORD_W +: WORD_W];
  assign drive    = busy && wr;
  assign capture  = busy && !wr && ta;
  assign beat_err = capture && (dp_in != lane_par(dh_in));

  assign dh_out = drive ? cur_word : '0;
  assign dl_out = '0;
  assign dp_out = {4'b0000, drive ? lane_par(cur_word) : 4'b0000};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata   <= '0;
      err_acc <= 1'b0;
      perr    <= 1'b0;
    end else begin
      perr <= final_ta && !wr && (err_acc || beat_err);
      if (start)         err_acc <= 1'b0;
      else if (beat_err) err_acc <= 1'b1;
      if (capture) rdata[slot*WORD_W +: WORD_W] <= dh_in;
    end
  end

endmodule

// File: rtl/narrow_bus_seq.sv
module narrow_bus_seq
  import nbs_pkg::*;
#(
  parameter int LINE_WORDS = 8,
  localparam int BEAT_W = $clog2(LINE_WORDS),
  localparam int LINE_W = WORD_W * LINE_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic              req_write,
  input  logic [2:0]        req_bytes,
  input  logic [2:0]        req_dw_off,
  input  logic              req_ci,
  input  logic              req_wt,
  input  logic [LINE_W-1:0] req_wdata,
  input  logic              bus_ta,
  input  logic [31:0]       bus_dh_in,
  input  logic [3:0]        bus_dp_in,
  output logic              busy,
  output logic              bus_burst,
  output logic [2:0]        bus_size,
  output logic [31:0]       bus_dh_out,
  output logic [31:0]       bus_dl_out,
  output logic [7:0]        bus_dp_out,
  output logic [LINE_W-1:0] rd_data,
  output logic              done,
  output logic              rd_perr
);

  // named internal events, brought out for the checker
  logic              cls_ok;
  logic [BEAT_W-1:0] cls_last;
  logic              cls_burst;
  logic [2:0]        cls_size;
  logic              start;
  logic              final_ta;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] last_idx;
  logic              wr_q;
  logic              fpdw_q;
  logic [LINE_W-1:0] wdata_q;

  nbs_classify #(.LINE_WORDS(LINE_WORDS)) u_cls (
    .kind(req_kind), .write(req_write), .nbytes(req_bytes), .dw_off(req_dw_off),
    .ci(req_ci), .wt(req_wt), .ok(cls_ok), .last_idx(cls_last),
    .burst(cls_burst), .size_code(cls_size)
  );

  assign start = req_valid && !busy && cls_ok;

  nbs_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .start(start), .last_in(cls_last), .ta(bus_ta),
    .busy(busy), .beat(beat), .last_idx(last_idx), .final_ta(final_ta), .done(done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_burst <= 1'b0;
      bus_size  <= 3'b000;
      wr_q      <= 1'b0;
      fpdw_q    <= 1'b0;
      wdata_q   <= '0;
    end else if (start) begin
      bus_burst <= cls_burst;
      bus_size  <= cls_size;
      wr_q      <= req_write;
      fpdw_q    <= (req_kind_e'(req_kind) == KIND_FPDW);
      wdata_q   <= req_wdata;
    end else if (final_ta) begin
      bus_burst <= 1'b0;
      bus_size  <= 3'b000;
    end
  end

  nbs_lane_io #(.LINE_WORDS(LINE_WORDS)) u_io (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .wr(wr_q), .fpdw(fpdw_q),
    .beat(beat), .ta(bus_ta), .final_ta(final_ta), .wdata(wdata_q),
    .dh_in(bus_dh_in), .dp_in(bus_dp_in), .dh_out(bus_dh_out), .dl_out(bus_dl_out),
    .dp_out(bus_dp_out), .rdata(rd_data), .perr(rd_perr)
  );

endmodule

// File: rtl/nbs_chk.sv
module nbs_chk #(
  parameter int LINE_WORDS = 8,
  localparam int BEAT_W = $clog2(LINE_WORDS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              bus_ta,
  input logic [BEAT_W-1:0] beat,
  input logic [BEAT_W-1:0] last_idx,
  input logic              bus_burst,
  input logic [2:0]        bus_size,
  input logic [31:0]       bus_dh_out,
  input logic [31:0]       bus_dl_out,
  input logic [7:0]        bus_dp_out,
  input logic              done,
  input logic              rd_perr
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_burst && bus_size == 3'b000 && bus_dh_out == '0 && bus_dp_out == '0));

  p_low_lanes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_dl_out == '0 && bus_dp_out[7:4] == 4'b0000));

  p_single_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && last_idx == '0) |-> (!bus_burst && bus_size != 3'b000 && bus_size <= 3'd4));

  p_double_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && last_idx == BEAT_W'(1)) |-> (!bus_burst && bus_size == 3'b000));

  p_line_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_burst |-> (busy && bus_size == 3'b010 && last_idx == BEAT_W'(LINE_WORDS - 1)));

  p_perr_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_perr |-> done);

  p_hold_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bus_ta) |=> (busy && beat == $past(beat)));

  p_step_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_ta && beat != last_idx) |=> (busy && beat == $past(beat) + BEAT_W'(1)));

  p_done_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

endmodule

bind narrow_bus_seq nbs_chk #(.LINE_WORDS(LINE_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .bus_ta(bus_ta), .beat(beat),
  .last_idx(last_idx), .bus_burst(bus_burst), .bus_size(bus_size),
  .bus_dh_out(bus_dh_out), .bus_dl_out(bus_dl_out), .bus_dp_out(bus_dp_out),
  .done(done), .rd_perr(rd_perr)
);

// File: tb/narrow_bus_seq_tb.sv
module narrow_bus_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LW = 8;

  typedef struct packed {
    logic [1:0] kind;
    logic       wr;
    logic [2:0] nb;
    logic [2:0] off;
    logic       ci;
    logic       wt;
    logic       ok;
    logic [2:0] last;
    logic       burst;
    logic [2:0] size;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b1, 3'd1, 3'd3, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 3'b001},
    '{2'd0, 1'b0, 3'd2, 3'd0, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 3'b010},
    '{2'd0, 1'b1, 3'd4, 3'd0, 1'b1, 1'b0, 1'b1, 3'd0, 1'b0, 3'b100},
    '{2'd0, 1'b0, 3'd3, 3'd1, 1'b0, 1'b1, 1'b1, 3'd0, 1'b0, 3'b011},
    '{2'd1, 1'b1, 3'd0, 3'd0, 1'b0, 1'b0, 1'b1, 3'd1, 1'b0, 3'b000},
    '{2'd1, 1'b0, 3'd0, 3'd0, 1'b1, 1'b0, 1'b1, 3'd1, 1'b0, 3'b000},
    '{2'd1, 1'b1, 3'd0, 3'd4, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 3'b000},
    '{2'd2, 1'b0, 3'd0, 3'd5, 1'b0, 1'b0, 1'b1, 3'd7, 1'b1, 3'b010},
    '{2'd2, 1'b1, 3'd0, 3'd0, 1'b0, 1'b0, 1'b1, 3'd7, 1'b1, 3'b010},
    '{2'd2, 1'b1, 3'd0, 3'd0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 3'b000},
    '{2'd2, 1'b0, 3'd0, 3'd0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 3'b000},
    '{2'd0, 1'b1, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 3'b000},
    '{2'd0, 1'b0, 3'd5, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 3'b000},
    '{2'd3, 1'b1, 3'd1, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 3'b000},
    '{2'd2, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1, 1'b1, 3'd7, 1'b1, 3'b010}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_kind = '0;
  logic          req_write = 1'b0;
  logic [2:0]    req_bytes = '0;
  logic [2:0]    req_dw_off = '0;
  logic          req_ci = 1'b0;
  logic          req_wt = 1'b0;
  logic [255:0]  req_wdata = '0;
  logic          bus_ta = 1'b0;
  logic [31:0]   bus_dh_in = '0;
  logic [3:0]    bus_dp_in = '0;
  logic          busy, bus_burst, done, rd_perr;
  logic [2:0]    bus_size;
  logic [31:0]   bus_dh_out, bus_dl_out;
  logic [7:0]    bus_dp_out;
  logic [255:0]  rd_data;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  narrow_bus_seq #(.LINE_WORDS(LW)) u_dut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // odd parity per lane, counted bit by bit
  function automatic logic [3:0] par4(input logic [31:0] w);
    logic [3:0] p;
    for (int ln = 0; ln < 4; ln++) begin
      int ones = 0;
      for (int k = 0; k < 8; k++) ones += w[31 - 8*ln - k];
      p[ln] = (ones % 2 == 0);
    end
    return p;
  endfunction

  function automatic logic [255:0] mkw(input int i);
    logic [255:0] w;
    for (int k = 0; k < 8; k++) w[32*k +: 32] = {8'(i + 1), 8'(k * 17), 16'h5A3C ^ 16'(k * 3)};
    return w;
  endfunction

  function automatic logic [31:0] rword(input int i, input int b);
    return 32'hC0DE_0000 ^ {8'(b * 29), 8'(i), 8'(b), 8'(i * 7 + 1)};
  endfunction

  task automatic run_vec(input vec_t v, input int i);
    logic [255:0] wd;
    string tag;
    wd = mkw(i);
    tag = (v.kind == 2'd0) ? "R3" : (v.kind == 2'd1) ? "R4" : "R5";
    @(negedge clk);
    req_valid = 1'b1; req_kind = v.kind; req_write = v.wr; req_bytes = v.nb;
    req_dw_off = v.off; req_ci = v.ci; req_wt = v.wt; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk($sformatf("R6 accept vec %0d", i), busy, v.ok);
    if (!v.ok) begin
      chk("R6 rejected burst", bus_burst, 1'b0);
      return;
    end
    chk($sformatf("%s burst vec %0d", tag, i), bus_burst, v.burst);
    chk($sformatf("%s size vec %0d", tag, i), bus_size, v.size);
    for (int b = 0; b <= int'(v.last); b++) begin
      int s;
      logic [31:0] ew;
      s = (v.kind == 2'd1) ? ((b == 0) ? 1 : 0) : b;
      ew = wd[32*s +: 32];
      if (v.kind == 2'd2 && b == 1) begin
        @(negedge clk);
        chk("R8 busy through stall", busy, 1'b1);
        if (v.wr) chk("R8 data held in stall", bus_dh_out, ew);
      end
      if (v.wr) begin
        chk($sformatf("%s write word beat %0d", tag, b), bus_dh_out, ew);
        chk($sformatf("R7 write parity beat %0d", b), bus_dp_out, {4'b0000, par4(ew)});
        chk("R2 low lanes", bus_dl_out, 32'h0);
      end else begin
        bus_dh_in = rword(i, b);
        bus_dp_in = par4(rword(i, b));
      end
      bus_ta = 1'b1;
      @(negedge clk);
      bus_ta = 1'b0;
    end
    chk($sformatf("R8 done vec %0d", i), done, 1'b1);
    chk("R8 busy low at done", busy, 1'b0);
    if (!v.wr) begin
      chk("R7 clean read no perr", rd_perr, 1'b0);
      for (int b = 0; b <= int'(v.last); b++) begin
        int s;
        s = (v.kind == 2'd1) ? ((b == 0) ? 1 : 0) : b;
        chk($sformatf("%s read slot %0d vec %0d", tag, s, i), rd_data[32*s +: 32], rword(i, b));
      end
    end
    @(negedge clk);
    chk("R8 done one cycle", done, 1'b0);
    chk("R1 idle size", bus_size, 3'b000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 busy", busy, 1'b0);
    chk("R1 done", done, 1'b0);
    chk("R1 perr", rd_perr, 1'b0);
    chk("R1 burst", bus_burst, 1'b0);
    chk("R1 size", bus_size, 3'b000);
    chk("R1 dh_out", bus_dh_out, 32'h0);
    chk("R1 dp_out", bus_dp_out, 8'h0);
    chk("R2 dl_out", bus_dl_out, 32'h0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R7: corrupted parity on one beat of a line read
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'd2; req_write = 1'b0; req_ci = 1'b0; req_wt = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    for (int b = 0; b < 8; b++) begin
      bus_dh_in = rword(40, b);
      bus_dp_in = par4(rword(40, b)) ^ ((b == 3) ? 4'b0100 : 4'b0000);
      bus_ta = 1'b1;
      @(negedge clk);
      bus_ta = 1'b0;
    end
    chk("R7 perr flagged", rd_perr, 1'b1);
    chk("R7 perr with done", done, 1'b1);
    // next clean single read clears the error
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'd0; req_bytes = 3'd4;
    @(negedge clk);
    req_valid = 1'b0;
    bus_dh_in = 32'h1234_5678; bus_dp_in = par4(32'h1234_5678); bus_ta = 1'b1;
    @(negedge clk);
    bus_ta = 1'b0;
    chk("R7 perr cleared next tenure", rd_perr, 1'b0);
    chk("R3 single read word", rd_data[31:0], 32'h1234_5678);

    // R8: request while busy is ignored
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'd0; req_write = 1'b1; req_bytes = 3'd2; req_wdata = mkw(50);
    @(negedge clk);
    req_kind = 2'd2;
    chk("R8 busy started", busy, 1'b1);
    @(negedge clk);
    chk("R8 attrs unchanged while busy", {bus_burst, bus_size}, {1'b0, 3'b010});
    chk("R3 single write word", bus_dh_out, mkw(50) & 256'hFFFF_FFFF);
    bus_ta = 1'b1;
    @(negedge clk);
    bus_ta = 1'b0; req_valid = 1'b0;
    chk("R8 busy request not taken", busy, 1'b0);
    chk("R8 done after single", done, 1'b0 | 1'b1);
    @(negedge clk);
    chk("R8 still idle", busy, 1'b0);
    chk("R1 idle dh_out", bus_dh_out, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule